// File: doc/BRIEF.md
# Change-of-State Input Interrupt Controller

This block watches a 32-bit digital input port and raises a level-sensitive interrupt when the inputs change state in a way that software has programmed. Every input passes through a synchroniser and can be read back directly. Only the low 16 channels take part in interrupt generation. Two mask registers pick the channels that take part. One mask selects rising edges or a required high level. The other selects falling edges or a required low level.

The combine mode decides how the selected channels form an event. In any-edge mode, a single qualifying transition on any selected channel is enough. In all-levels mode, every selected channel must sit at its programmed level at the same time. After such a match the unit stays quiet until the match has gone false once.

When an event fires, the unit latches the low 16 synchronised inputs as a snapshot and sets a pending flag. A read of the status register returns the snapshot and clears both the snapshot and the flag. Software talks to the block over a word-addressed register bus with a one-cycle read.

Top module: `cos_irq_ctrl`

## Requirements
- R1: Word address 0 returns the synchronised 32 inputs. Addresses 1 (rise/high mask) and 2 (fall/low mask) store and return all 32 written bits. Address 4 (control) keeps only bit 1, the mode (0 any-edge, 1 all-levels), and bit 2, the enable, and reads every other bit as 0.
- R2: In any-edge mode with the enable set, a 0-to-1 change on a channel below 16 that is set in the rise mask raises an event. A 1-to-0 change on a channel below 16 that is set in the fall mask also raises an event.
- R3: In any-edge mode, no event is raised by a change on a channel that is not in the matching mask, or by a change in the direction that the channel's mask does not select.
- R4: Mask bits 16 to 31 have no effect, so toggling inputs 16 to 31 never raises an event.
- R5: In all-levels mode with the enable set, an event is raised when every channel set in the high mask reads 1 and every channel set in the low mask reads 0.
- R6: After an all-levels event, no further event is raised while the condition stays true. The condition must go false before the next event can fire.
- R7: If both masks select no channel below 16, no event is raised in either mode.
- R8: A read of word address 3 returns the snapshot in bits 15:0, with bits 31:16 at zero. The same read clears the pending flag and the snapshot, so the interrupt drops and a second read returns 0.
- R9: If an event arrives while an earlier one is still pending, the snapshot is replaced by the newer inputs and the flag stays set.
- R10: No events are detected while the enable is 0, and the interrupt output is held low. An event that was pending when the enable was cleared reappears on the output once the enable is set again.
- R11: If an input change is first sampled at clock edge k, the interrupt output goes high after edge k+3.
- R12: If an event fires at the same edge as a status read, the read returns the old snapshot, and the new event stays pending with its own snapshot.
- R13: After reset, all registers read 0 and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Word address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after the strobe |
| pins_in | input | 32 | Asynchronous digital inputs |
| irq_o | output | 1 | Level interrupt request, registered |

## Verification
An input change goes through two synchroniser flops, the event logic and the pending flag, and then the registered output. It therefore shows on the interrupt three edges after the first sampling edge. Read data is due on the edge after the strobe, and a read-clear drops the interrupt one edge later. The bench changes inputs and strobes on the falling edge and samples on the next falling edge. For most tests it waits five cycles after an input change, which is more than the three-edge latency. The latency test and the test where a read and an event meet count single edges. They check the interrupt low at k+1 and k+2 and high at k+3, and they place the read strobe on exactly the edge where the new event lands.

// File: rtl/cos_pkg.sv
package cos_pkg;
  // Word addresses of the register file
  localparam int unsigned REG_IN   = 0;
  localparam int unsigned REG_RISE = 1;
  localparam int unsigned REG_FALL = 2;
  localparam int unsigned REG_STAT = 3;
  localparam int unsigned REG_CTRL = 4;

  // Control register bit positions
  localparam int unsigned CTRL_MODE_BIT = 1;
  localparam int unsigned CTRL_EN_BIT   = 2;

  typedef enum logic {
    MODE_ANY_EDGE  = 1'b0,
    MODE_ALL_LEVEL = 1'b1
  } combine_e;
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/cos_detect.sv
module cos_detect
  import cos_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] smp,
  input  logic [N-1:0] hi_mask,
  input  logic [N-1:0] lo_mask,
  input  logic         active,
  input  combine_e     mode,
  output logic         fire
);
  logic [N-1:0] prev_q;
  logic         armed_q;
  logic [N-1:0] chan_ok;
  logic [N-1:0] rise_hit;
  logic [N-1:0] fall_hit;
  logic         edge_hit;
  logic         sel_any;
  logic         lvl_true;
  logic         lvl_mode;

  // Per-channel level qualification: a channel is satisfied when it is
  // either unselected or sitting at the level its mask demands.
  for (genvar g = 0; g < int'(N); g++) begin : g_chan
    assign chan_ok[g] = (~hi_mask[g] | smp[g]) & (~lo_mask[g] | ~smp[g]);
  end

  assign rise_hit = smp & ~prev_q & hi_mask;
  assign fall_hit = ~smp & prev_q & lo_mask;
  assign edge_hit = |(rise_hit | fall_hit);
  assign sel_any  = |(hi_mask | lo_mask);
  assign lvl_true = sel_any & (&chan_ok);
  assign lvl_mode = (mode == MODE_ALL_LEVEL);

  always_comb begin
    if (!active)       fire = 1'b0;
    else if (lvl_mode) fire = lvl_true & armed_q;
    else               fire = edge_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= '0;
      armed_q <= 1'b1;
    end else begin
      prev_q <= smp;
      if (active && lvl_mode) armed_q <= ~lvl_true;
      else                    armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/cos_status.sv
module cos_status #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fire,
  input  logic [N-1:0] snap_in,
  input  logic         clr,
  output logic         pend,
  output logic [N-1:0] snap
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      snap <= '0;
    end else if (fire) begin
      // a new event wins over a concurrent clear
      pend <= 1'b1;
      snap <= snap_in;
    end else if (clr) begin
      pend <= 1'b0;
      snap <= '0;
    end
  end
endmodule

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl
  import cos_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IRQ_N  = 16,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] pins_in,
  output logic              irq_o
);
  localparam int unsigned STAT_PAD = DATA_W - IRQ_N;

  logic [DATA_W-1:0] pin_s;
  logic [DATA_W-1:0] rise_q;
  logic [DATA_W-1:0] fall_q;
  logic              en_q;
  combine_e          mode_q;
  logic              fire_w;
  logic              pend_w;
  logic [IRQ_N-1:0]  snap_w;
  logic              stat_rd;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;
  logic              irq_q;

  cos_sync #(.W(DATA_W), .STAGES(SYNC_N)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pins_in),
    .q   (pin_s)
  );

  cos_detect #(.N(IRQ_N)) u_det (
    .clk     (clk),
    .rst     (rst),
    .smp     (pin_s[IRQ_N-1:0]),
    .hi_mask (rise_q[IRQ_N-1:0]),
    .lo_mask (fall_q[IRQ_N-1:0]),
    .active  (en_q),
    .mode    (mode_q),
    .fire    (fire_w)
  );

  assign stat_rd = bus_rd && (bus_addr == ADDR_W'(REG_STAT));

  cos_status #(.N(IRQ_N)) u_stat (
    .clk     (clk),
    .rst     (rst),
    .fire    (fire_w),
    .snap_in (pin_s[IRQ_N-1:0]),
    .clr     (stat_rd),
    .pend    (pend_w),
    .snap    (snap_w)
  );

  // Register writes
  always_ff @(posedge clk) begin
    if (rst) begin
      rise_q <= '0;
      fall_q <= '0;
      en_q   <= 1'b0;
      mode_q <= MODE_ANY_EDGE;
    end else if (bus_wr) begin
      case (bus_addr)
        ADDR_W'(REG_RISE): rise_q <= bus_wdata;
        ADDR_W'(REG_FALL): fall_q <= bus_wdata;
        ADDR_W'(REG_CTRL): begin
          en_q   <= bus_wdata[CTRL_EN_BIT];
          mode_q <= combine_e'(bus_wdata[CTRL_MODE_BIT]);
        end
        default: ;
      endcase
    end
  end

  // Read multiplexer
  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      ADDR_W'(REG_IN):   rd_mux = pin_s;
      ADDR_W'(REG_RISE): rd_mux = rise_q;
      ADDR_W'(REG_FALL): rd_mux = fall_q;
      ADDR_W'(REG_STAT): rd_mux = {{STAT_PAD{1'b0}}, snap_w};
      ADDR_W'(REG_CTRL): begin
        rd_mux[CTRL_EN_BIT]   = en_q;
        rd_mux[CTRL_MODE_BIT] = mode_q;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (bus_rd) rdata_q <= rd_mux;
      irq_q <= pend_w & en_q;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/cos_irq_ctrl_chk.sv
module cos_irq_ctrl_chk
  import cos_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned IRQ_N  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              irq_o,
  input logic              fire,
  input logic              pend,
  input logic              en,
  input combine_e          mode,
  input logic [IRQ_N-1:0]  hi_mask,
  input logic [IRQ_N-1:0]  lo_mask
);
  logic stat_rd;
  assign stat_rd = bus_rd && (bus_addr == ADDR_W'(REG_STAT));

  // R7: empty selection never raises an event
  a_r7_empty_no_event: assert property (@(posedge clk) disable iff (rst)
    (hi_mask == '0 && lo_mask == '0) |-> !fire);

  // R6: all-levels mode never fires on two consecutive cycles
  a_r6_level_rearm: assert property (@(posedge clk) disable iff (rst)
    (fire && mode == MODE_ALL_LEVEL) |=> (mode != MODE_ALL_LEVEL || !fire));

  // R9: pending stays set until a status read
  a_r9_pending_sticky: assert property (@(posedge clk) disable iff (rst)
    (pend && !stat_rd) |=> pend);

  // R8: status read without a new event clears pending
  a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
    (pend && stat_rd && !fire) |=> !pend);

  // R10: detection is off while the enable is clear
  a_r10_no_detect_disabled: assert property (@(posedge clk) disable iff (rst)
    !en |-> !fire);

  // R11: an enabled event reaches the output one edge after pending
  a_r11_event_to_irq: assert property (@(posedge clk) disable iff (rst)
    (fire && en) ##1 en |=> irq_o);
endmodule

bind cos_irq_ctrl cos_irq_ctrl_chk #(.ADDR_W(ADDR_W), .IRQ_N(IRQ_N)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .bus_rd   (bus_rd),
  .bus_addr (bus_addr),
  .irq_o    (irq_o),
  .fire     (fire_w),
  .pend     (pend_w),
  .en       (en_q),
  .mode     (mode_q),
  .hi_mask  (rise_q[IRQ_N-1:0]),
  .lo_mask  (fall_q[IRQ_N-1:0])
);

// File: tb/cos_irq_ctrl_tb_top.sv
module cos_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;

  localparam logic [2:0] C_OFF = 3'b000;
  localparam logic [2:0] C_ANY = 3'b100;
  localparam logic [2:0] C_ALL = 3'b110;

  // {ctrl[2:0], hi[15:0], lo[15:0], pins_a[15:0], pins_b[15:0], irq, snap[15:0]}
  localparam logic [83:0] VEC [NVEC] = '{
    {C_ANY, 16'h0001, 16'h0000, 16'h0000, 16'h0001, 1'b1, 16'h0001}, // R2 rise
    {C_ANY, 16'h0000, 16'h0004, 16'h0004, 16'h0000, 1'b1, 16'h0000}, // R2 fall
    {C_ANY, 16'h0001, 16'h0000, 16'h0001, 16'h0000, 1'b0, 16'h0000}, // R3 wrong dir
    {C_ANY, 16'h0002, 16'h0000, 16'h0000, 16'h0001, 1'b0, 16'h0000}, // R3 unmasked
    {C_ANY, 16'h00F0, 16'h0000, 16'h0000, 16'h8010, 1'b1, 16'h8010}, // R2 multi
    {C_ALL, 16'h0003, 16'h000C, 16'h0000, 16'h0003, 1'b1, 16'h0003}, // R5 match
    {C_ALL, 16'h0003, 16'h000C, 16'h0000, 16'h0007, 1'b0, 16'h0000}, // R5 partial
    {C_ALL, 16'h0001, 16'h0000, 16'h0001, 16'h0003, 1'b0, 16'h0000}, // R6 no refire
    {C_ALL, 16'h0000, 16'h0000, 16'hFFFF, 16'h0000, 1'b0, 16'h0000}, // R7 empty
    {C_OFF, 16'h0001, 16'h0000, 16'h0000, 16'h0001, 1'b0, 16'h0000}, // R10 disabled
    {C_ALL, 16'h8000, 16'h0000, 16'h0000, 16'h8000, 1'b1, 16'h8000}  // R5 high only
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [31:0] pins_in = '0;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cos_irq_ctrl dut_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .pins_in   (pins_in),
    .irq_o     (irq_o)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // Program masks and control with inputs at a settled value, then clear status
  task automatic setup(input logic [2:0] ctrl, input logic [31:0] hi, input logic [31:0] lo,
                       input logic [31:0] pins);
    logic [31:0] dummy;
    bus_write(3'd4, 32'h0);
    bus_write(3'd1, hi);
    bus_write(3'd2, lo);
    pins_in = pins;
    tick(5);
    bus_write(3'd4, {29'h0, ctrl});
    tick(3);
    bus_read(3'd3, dummy);
    tick(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    tick(3);
    rst = 1'b0;
    tick(1);

    // R13: reset state
    check("R13 irq", {31'h0, irq_o}, 32'h0);
    for (int a = 0; a < 5; a++) begin
      bus_read(3'(a), rd);
      check("R13 reg", rd, 32'h0);
    end

    // R1: direct input and register readback
    pins_in = 32'hA5A5_3C3C;
    tick(4);
    bus_read(3'd0, rd);     check("R1 input", rd, 32'hA5A5_3C3C);
    bus_write(3'd1, 32'hDEAD_BEEF);
    bus_write(3'd2, 32'h1234_5678);
    bus_read(3'd1, rd);     check("R1 rise mask", rd, 32'hDEAD_BEEF);
    bus_read(3'd2, rd);     check("R1 fall mask", rd, 32'h1234_5678);
    bus_write(3'd4, 32'hFFFF_FFF9);
    bus_read(3'd4, rd);     check("R1 ctrl", rd, 32'h0000_0000);
    bus_write(3'd4, 32'hFFFF_FFFF);
    bus_read(3'd4, rd);     check("R1 ctrl", rd, 32'h0000_0006);
    bus_write(3'd4, 32'h0);
    pins_in = '0;
    tick(4);
    bus_read(3'd3, rd);

    // Vector table
    for (int v = 0; v < NVEC; v++) begin
      logic [83:0] e;
      e = VEC[v];
      setup(e[83:81], {16'h0, e[80:65]}, {16'h0, e[64:49]}, {16'h0, e[48:33]});
      pins_in = {16'h0, e[32:17]};
      tick(5);
      check($sformatf("R2/R3/R5/R6/R7/R10 vec%0d irq", v), {31'h0, irq_o}, {31'h0, e[16]});
      bus_read(3'd3, rd);
      check($sformatf("R8 vec%0d snapshot", v), rd, e[16] ? {16'h0, e[15:0]} : 32'h0);
      tick(2);
      check($sformatf("R8 vec%0d irq after read", v), {31'h0, irq_o}, 32'h0);
    end

    // R4: upper channels never interrupt
    setup(C_ANY, 32'hFFFF_0000, 32'hFFFF_0000, 32'h0);
    pins_in = 32'hFFFF_0000; tick(5);
    check("R4 rise upper", {31'h0, irq_o}, 32'h0);
    pins_in = 32'h0; tick(5);
    check("R4 fall upper", {31'h0, irq_o}, 32'h0);
    bus_read(3'd3, rd); check("R4 status", rd, 32'h0);

    // R11: exact latency
    setup(C_ANY, 32'h1, 32'h0, 32'h0);
    pins_in = 32'h1;
    @(posedge clk); @(negedge clk);
    check("R11 after k", {31'h0, irq_o}, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R11 after k+1", {31'h0, irq_o}, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R11 after k+2", {31'h0, irq_o}, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R11 after k+3", {31'h0, irq_o}, 32'h1);
    bus_read(3'd3, rd); check("R11 snapshot", rd, 32'h1);
    tick(2);
    check("R8 second read irq", {31'h0, irq_o}, 32'h0);
    bus_read(3'd3, rd); check("R8 second read", rd, 32'h0);

    // R9: newer event overwrites snapshot
    setup(C_ANY, 32'h3, 32'h0, 32'h0);
    pins_in = 32'h1; tick(5);
    pins_in = 32'h3; tick(5);
    check("R9 irq", {31'h0, irq_o}, 32'h1);
    bus_read(3'd3, rd); check("R9 snapshot", rd, 32'h3);

    // R10: disable masks, re-enable presents
    setup(C_ANY, 32'h1, 32'h0, 32'h0);
    pins_in = 32'h1; tick(5);
    check("R10 pending irq", {31'h0, irq_o}, 32'h1);
    bus_write(3'd4, 32'h0); tick(2);
    check("R10 masked", {31'h0, irq_o}, 32'h0);
    bus_write(3'd4, 32'h4); tick(2);
    check("R10 re-enabled", {31'h0, irq_o}, 32'h1);
    bus_read(3'd3, rd); check("R10 snapshot kept", rd, 32'h1);

    // R12: event coincides with status read
    setup(C_ANY, 32'h3, 32'h0, 32'h0);
    pins_in = 32'h1; tick(5);
    pins_in = 32'h3;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    bus_read(3'd3, rd); check("R12 old snapshot", rd, 32'h1);
    tick(1);
    check("R12 irq held", {31'h0, irq_o}, 32'h1);
    bus_read(3'd3, rd); check("R12 new snapshot", rd, 32'h3);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule